// File: doc/BRIEF.md
# Control-Block Command Handler

This block sits between a host CPU and the two execution engines of a descriptor-driven Ethernet controller. It handles the control word that the host places in a shared control block. When the host strobes channel attention, the handler captures the word and decodes it. In one step it then acknowledges interrupt causes, moves the command unit and receive unit to their new states, and optionally performs a soft reset. The handler keeps a 16-bit status word that packs the pending cause bits with both unit states, so the host can read it back.

An attention can arrive while an earlier one is still being applied, or while the command unit reports that it is busy. Such attentions are counted, not lost. Each one is replayed in turn once the handler is free, and each replay samples the control word present at that time. After every applied word, the handler raises a start-list request when the command unit is not suspended and holds no list pointer. The command unit answers that request by fetching its pointer. It later reports through `list_null_i` that the pointer has run out.

Top module: `scb_cmd_handler`

## Requirements
- R1: Command-unit code in word bits 10:8: code 1 sets the command unit to active (2); code 4 sets it to suspended (1) and raises cause bit 13; code 0 leaves it unchanged.
- R2: Receive-unit code in word bits 6:4: codes 1 and 2 set the receiver to idle (0); codes 3 and 4 set it to suspended (1) and raise cause bit 12; code 0 leaves it unchanged.
- R3: Cause bits 15:12 are set by `cause_set_i[3:0]` (bit 3 sets 15, bit 0 sets 12); a word with any of bits 15:12 set clears the same cause bits when applied.
- R4: Word bit 7 forces command unit idle (0), receiver suspended (1), all causes cleared and the list pointer invalid, and pulses `soft_rst_o`; the reset overrides both codes in the same word.
- R5: `status_o` equals causes in bits 15:12, command-unit state in bits 9:8, receive-unit state in bits 6:4, all other bits zero; after reset it reads 0x0010.
- R6: When an applied word leaves the command unit not suspended and no pointer is held, `list_req_o` pulses once and the pointer counts as held until `list_null_i` or a soft reset.
- R7: An attention arriving while a word is being applied or while `cu_busy_i` is high increments a pending count; each pending attention is later applied, giving one `done_o` pulse each.
- R8: Command-unit codes 2, 3, 5, 6, 7 and receive-unit codes 5, 6, 7 leave the respective state unchanged and pulse `err_o`.
- R9: The word is captured on the clock edge that accepts the attention; all updates and the `done_o`, `list_req_o` and `err_o` pulses appear together after the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| attn_i | input | 1 | Channel-attention strobe |
| cmd_word_i | input | 16 | Control word from the control block |
| cu_busy_i | input | 1 | Command unit is executing its list; defers attentions |
| cause_set_i | input | 4 | Cause set strobes for status bits 15:12 |
| list_null_i | input | 1 | Command unit has no valid list pointer any more |
| status_o | output | 16 | Composed status word |
| cu_state_o | output | 2 | Command-unit state (0 idle, 1 suspended, 2 active) |
| ru_state_o | output | 3 | Receive-unit state (0 idle, 1 suspended) |
| soft_rst_o | output | 1 | One-cycle soft-reset pulse |
| list_req_o | output | 1 | One-cycle start-list request |
| done_o | output | 1 | One-cycle pulse per applied word |
| err_o | output | 1 | One-cycle pulse for an unknown control code |

## Verification
The hardest case to reach is the replay path. Here attentions pile up behind a busy command unit or behind a word still in flight, and the pending counter must drain exactly as many times as strobes came in. The bench holds `cu_busy_i` high while it strobes several times. It also holds the strobe for two back-to-back cycles so that one lands in the apply cycle. It then counts `done_o` pulses and compares the final state with a model that applies the same word once per counted attention. Random words with all code values, random acknowledge bits and occasional reset bits cover decoding and status composition.

// File: rtl/scb_cmd_handler.sv
module scb_cmd_handler #(
  parameter int PEND_W = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        attn_i,
  input  logic [15:0] cmd_word_i,
  input  logic        cu_busy_i,
  input  logic [3:0]  cause_set_i,
  input  logic        list_null_i,
  output logic [15:0] status_o,
  output logic [1:0]  cu_state_o,
  output logic [2:0]  ru_state_o,
  output logic        soft_rst_o,
  output logic        list_req_o,
  output logic        done_o,
  output logic        err_o
);

  localparam logic [PEND_W-1:0] PEND_MAX = '1;
  localparam logic [1:0] CU_IDLE = 2'd0, CU_SUSP = 2'd1, CU_ACT = 2'd2;
  localparam logic [2:0] RU_IDLE = 3'd0, RU_SUSP = 3'd1;

  logic              active_q, ptr_q;
  logic [15:0]       cap_q;
  logic [PEND_W-1:0] pend_q;
  logic [3:0]        cause_q;

  wire [2:0] cuc  = cap_q[10:8];
  wire [2:0] ruc  = cap_q[6:4];
  wire       srst = cap_q[7];
  wire       go   = !active_q && !cu_busy_i && (attn_i || pend_q != '0);

  logic [1:0] cu_n;
  logic [2:0] ru_n;
  logic [3:0] cause_n;
  logic       bad_n, ptr_n, req_n;

  always_comb begin
    cu_n    = cu_state_o;
    ru_n    = ru_state_o;
    cause_n = cause_q & ~cap_q[15:12];
    bad_n   = 1'b0;
    case (cuc)
      3'd0: ;
      3'd1: cu_n = CU_ACT;
      3'd4: begin cu_n = CU_SUSP; cause_n[1] = 1'b1; end
      default: bad_n = 1'b1;
    endcase
    case (ruc)
      3'd0: ;
      3'd1, 3'd2: ru_n = RU_IDLE;
      3'd3, 3'd4: begin ru_n = RU_SUSP; cause_n[0] = 1'b1; end
      default: bad_n = 1'b1;
    endcase
    cause_n = cause_n | cause_set_i;
    ptr_n   = ptr_q;
    if (srst) begin
      cu_n    = CU_IDLE;
      ru_n    = RU_SUSP;
      cause_n = '0;
      ptr_n   = 1'b0;
    end
    req_n = (cu_n != CU_SUSP) && !ptr_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      cap_q      <= '0;
      pend_q     <= '0;
      cause_q    <= '0;
      ptr_q      <= 1'b0;
      cu_state_o <= CU_IDLE;
      ru_state_o <= RU_SUSP;
      soft_rst_o <= 1'b0;
      list_req_o <= 1'b0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      soft_rst_o <= 1'b0;
      list_req_o <= 1'b0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      if (go) begin
        cap_q    <= cmd_word_i;
        active_q <= 1'b1;
        if (pend_q != '0) pend_q <= pend_q - PEND_W'(1) + PEND_W'(attn_i);
      end else begin
        active_q <= 1'b0;
        if (attn_i && pend_q != PEND_MAX) pend_q <= pend_q + PEND_W'(1);
      end
      if (active_q) begin
        cu_state_o <= cu_n;
        ru_state_o <= ru_n;
        cause_q    <= cause_n;
        ptr_q      <= ptr_n | req_n;
        soft_rst_o <= srst;
        list_req_o <= req_n;
        done_o     <= 1'b1;
        err_o      <= bad_n;
      end else begin
        cause_q <= cause_q | cause_set_i;
        if (list_null_i) ptr_q <= 1'b0;
      end
    end
  end

  assign status_o = {cause_q, 2'b00, cu_state_o, 1'b0, ru_state_o, 4'b0000};

  p_reset_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |-> (cu_state_o == CU_IDLE && ru_state_o == RU_SUSP && status_o[15:12] == 4'b0000));

  p_done_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_req_not_susp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    list_req_o |-> (cu_state_o != CU_SUSP && done_o));

  p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o);

  p_cu_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cu_state_o != 2'd3);

  p_apply_follows_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !go);

endmodule

// File: tb/scb_cmd_handler_tb.sv
`timescale 1ns/1ps
module scb_cmd_handler_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        attn_i = 1'b0;
  logic [15:0] cmd_word_i = '0;
  logic        cu_busy_i = 1'b0;
  logic [3:0]  cause_set_i = '0;
  logic        list_null_i = 1'b0;
  logic [15:0] status_o;
  logic [1:0]  cu_state_o;
  logic [2:0]  ru_state_o;
  logic        soft_rst_o, list_req_o, done_o, err_o;

  always #2.5 clk = ~clk;

  scb_cmd_handler u_dut (
    .clk(clk), .rst_n(rst_n), .attn_i(attn_i), .cmd_word_i(cmd_word_i),
    .cu_busy_i(cu_busy_i), .cause_set_i(cause_set_i), .list_null_i(list_null_i),
    .status_o(status_o), .cu_state_o(cu_state_o), .ru_state_o(ru_state_o),
    .soft_rst_o(soft_rst_o), .list_req_o(list_req_o), .done_o(done_o), .err_o(err_o)
  );

  int total = 0, bad = 0, done_cnt = 0;
  bit finished = 0;
  logic [1:0] m_cu = 2'd0;
  logic [2:0] m_ru = 3'd1;
  logic [3:0] m_cause = '0;
  bit m_ptr = 0, e_req, e_err, e_rst;

  always @(negedge clk) if (done_o) done_cnt++;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_status();
    return {m_cause, 2'b00, m_cu, 1'b0, m_ru, 4'b0000};
  endfunction

  task automatic model_apply(input logic [15:0] w);
    m_cause = m_cause & ~w[15:12];
    e_err = 0;
    case (w[10:8])
      3'd0: ;
      3'd1: m_cu = 2'd2;
      3'd4: begin m_cu = 2'd1; m_cause[1] = 1'b1; end
      default: e_err = 1;
    endcase
    case (w[6:4])
      3'd0: ;
      3'd1, 3'd2: m_ru = 3'd0;
      3'd3, 3'd4: begin m_ru = 3'd1; m_cause[0] = 1'b1; end
      default: e_err = 1;
    endcase
    e_rst = w[7];
    if (w[7]) begin m_cu = 2'd0; m_ru = 3'd1; m_cause = '0; m_ptr = 0; end
    e_req = (m_cu != 2'd1) && !m_ptr;
    if (e_req) m_ptr = 1;
  endtask

  task automatic do_attn(input logic [15:0] w, input string tag);
    @(negedge clk); attn_i = 1'b1; cmd_word_i = w;
    @(negedge clk); attn_i = 1'b0;
    @(negedge clk);
    model_apply(w);
    check(done_o == 1'b1, {tag, " R9 done"}, done_o, 1);
    check(status_o == exp_status(), {tag, " R5 status"}, status_o, exp_status());
    check(list_req_o == e_req, {tag, " R6 list_req"}, list_req_o, e_req);
    check(err_o == e_err, {tag, " R8 err"}, err_o, e_err);
    check(soft_rst_o == e_rst, {tag, " R4 soft_rst"}, soft_rst_o, e_rst);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(status_o == 16'h0010, "R5 reset status", status_o, 16'h0010);
    check(done_o == 0 && list_req_o == 0 && err_o == 0, "R9 reset pulses", {done_o, list_req_o, err_o}, 0);

    do_attn(16'h0100, "R1 cu start");
    check(cu_state_o == 2'd2, "R1 cu active", cu_state_o, 2);
    do_attn(16'h0010, "R2 ru start");
    check(ru_state_o == 3'd0, "R2 ru idle", ru_state_o, 0);
    do_attn(16'h0440, "R1 R2 abort both");
    check(status_o == 16'h3110, "R1 R2 abort causes", status_o, 16'h3110);
    do_attn(16'h2000, "R3 ack cna");
    do_attn(16'h0250, "R8 unknown codes");
    check(cu_state_o == 2'd1 && ru_state_o == 3'd1, "R8 state held", {cu_state_o, ru_state_o}, {2'd1, 3'd1});

    @(negedge clk); cause_set_i = 4'b1100;
    @(negedge clk); cause_set_i = 4'b0000;
    m_cause = m_cause | 4'b1100;
    check(status_o == exp_status(), "R3 cause set", status_o, exp_status());
    do_attn(16'h4000, "R3 ack fr");
    do_attn(16'h01A0, "R4 reset overrides");
    check(status_o == 16'h0010, "R4 reset status", status_o, 16'h0010);

    do_attn(16'h0100, "R6 held ptr");
    @(negedge clk); list_null_i = 1'b1;
    @(negedge clk); list_null_i = 1'b0;
    m_ptr = 0;
    do_attn(16'h0000, "R6 after null");

    @(negedge clk); cu_busy_i = 1'b1; cmd_word_i = 16'h0420;
    repeat (3) begin
      @(negedge clk); attn_i = 1'b1;
      @(negedge clk); attn_i = 1'b0;
    end
    repeat (2) @(negedge clk);
    check(cu_state_o == m_cu && ru_state_o == m_ru, "R7 deferred while busy", {cu_state_o, ru_state_o}, {m_cu, m_ru});
    done_cnt = 0;
    cu_busy_i = 1'b0;
    repeat (12) @(negedge clk);
    repeat (3) model_apply(16'h0420);
    check(done_cnt == 3, "R7 replay count", done_cnt, 3);
    check(status_o == exp_status(), "R7 replay state", status_o, exp_status());

    done_cnt = 0;
    @(negedge clk); attn_i = 1'b1; cmd_word_i = 16'h0100;
    @(negedge clk);
    @(negedge clk); attn_i = 1'b0;
    repeat (6) @(negedge clk);
    repeat (2) model_apply(16'h0100);
    check(done_cnt == 2, "R7 back-to-back count", done_cnt, 2);
    check(status_o == exp_status(), "R7 back-to-back state", status_o, exp_status());

    for (int i = 0; i < 300; i++) begin
      logic [15:0] w;
      w = 16'($urandom);
      if (($urandom % 8) != 0) w[7] = 1'b0;
      do_attn(w, "R1 R2 R3 random");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule